// File: doc/BRIEF.md
# Programmable Parallel Port Channel

This block is one 24-line parallel I/O channel in the plain, unhandshaked style of a classic programmable peripheral interface. The lines form four groups: an 8-bit port A, an 8-bit port B, and port C, whose two 4-bit halves each have their own direction. A host reaches the channel through four byte-wide registers, selected by a 2-bit offset, with separate write and read strobes.

Each group owns an output latch. The latch accepts data whether the group is an input or an output. The group's output enables follow a mode word held in a configuration register. Port reads do not use the latches. A read samples the live pin levels, so a port that is driving returns what is actually on its pins. The pins themselves are presented as separate input values, output values and output enables, which suits an FPGA pad ring or an external tri-state buffer.

Top module: `ppi_channel`

## Requirements
- R1: Offset 0 selects port A, offset 1 port B, offset 2 port C and offset 3 the mode word. On the pin vectors, bits 7:0 are port A, bits 15:8 are port B, bits 19:16 are the lower half of port C and bits 23:20 are its upper half. In port C data, bits 3:0 map to the lower half and bits 7:4 to the upper half.
- R2: After reset, every output enable is 0, every output latch holds 0, `host_rdata` is 0, and the mode word reads back as 0x9B.
- R3: A mode word with bit 7 = 1 sets the group directions, with 1 meaning input: bit 4 controls port A, bit 1 port B, bit 3 the upper half of port C and bit 0 its lower half. Every output enable of an output group is 1, and every output enable of an input group is 0. The new enables appear on the cycle after the write.
- R4: A mode word written with bit 7 = 0 has no effect. The output enables and the mode word readback stay unchanged.
- R5: A write to a port offset loads that group's output latch on the next cycle, whatever the group's direction. `pin_out` always carries the latch contents, and the latch value reaches the line only while the group's enables are 1.
- R6: A read strobe at offset 0, 1 or 2 samples `pin_in` for that port at the clock edge. The result appears on `host_rdata` in the next cycle and is held there until the next read strobe. For a driving group, this returns the driven value.
- R7: A read at offset 3 returns the last mode word that was accepted.
- R8: A port C write loads both halves at once. The two halves keep independent directions, so a single port C read can mix driven bits with external bits.
- R9: Port data writes never change the output enables, and mode word writes never change the output latches.
- R10: Mode word 0x80 makes all 24 lines outputs, and mode word 0x9B makes all 24 lines inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Levels sampled on the lines |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Per-line output enables, 1 means driving |

## Verification
The bench models the pins as a resolved loop: a line reads the latch value where its enable is set, and an external value elsewhere. Driving with all groups as inputs and then with all groups as outputs separates a latch readback from a true pin readback. Mixed mode words, with port C split between the directions, expose a swapped direction bit or a swapped half. Words with bit 7 clear, and writes to a latch while its group is an input, show whether state leaks into the enables or onto the pins. A seeded random mix of writes, mode words, reads and external pin changes is then checked against a bench model after every operation.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;

  // register offsets (host-visible order)
  typedef enum logic [1:0] {
    SEL_PORT_A = 2'd0,
    SEL_PORT_B = 2'd1,
    SEL_PORT_C = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_e;

  localparam int NUM_GROUPS    = 4;   // A, B, C lower, C upper
  localparam int MODE_SET_BIT  = 7;
  localparam logic [7:0] MODE_RESET_WORD = 8'h9B;

  // group index: 0 = A, 1 = B, 2 = C lower, 3 = C upper
  function automatic int grp_width(input int g, input int dw);
    return (g < 2) ? dw : dw / 2;
  endfunction

  function automatic int grp_pin_lo(input int g, input int dw);
    case (g)
      0:       return 0;
      1:       return dw;
      2:       return 2 * dw;
      default: return 2 * dw + dw / 2;
    endcase
  endfunction

  function automatic int grp_data_lo(input int g, input int dw);
    return (g == 3) ? dw / 2 : 0;
  endfunction

  // mode word bit that selects the group's direction (1 = input)
  function automatic int grp_dir_bit(input int g);
    case (g)
      0:       return 4;
      1:       return 1;
      2:       return 0;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/ppi_host_decode.sv
`timescale 1ns/1ps
module ppi_host_decode
  import ppi_pkg::*;
(
  input  logic                  host_wr,
  input  logic [1:0]            host_addr,
  output logic [NUM_GROUPS-1:0] grp_wr,
  output logic                  mode_wr
);
  reg_sel_e sel;

  always_comb begin
    sel     = reg_sel_e'(host_addr);
    grp_wr  = '0;
    mode_wr = 1'b0;
    if (host_wr) begin
      case (sel)
        SEL_PORT_A: grp_wr[0] = 1'b1;
        SEL_PORT_B: grp_wr[1] = 1'b1;
        SEL_PORT_C: grp_wr[3:2] = 2'b11;
        default:    mode_wr = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ppi_mode_reg.sv
`timescale 1ns/1ps
module ppi_mode_reg
  import ppi_pkg::*;
#(
  parameter int DW = 8
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_wr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         mode_word,
  output logic [NUM_GROUPS-1:0] grp_is_in
);
  logic accept;
  assign accept = mode_wr && wdata[MODE_SET_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_word <= DW'(MODE_RESET_WORD);
      grp_is_in <= '1;
    end else if (accept) begin
      mode_word <= wdata;
      for (int g = 0; g < NUM_GROUPS; g++)
        grp_is_in[g] <= wdata[grp_dir_bit(g)];
    end
  end

  // R4: a word without the mode-set bit leaves all mode state alone
  a_r4_plain_word_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !wdata[MODE_SET_BIT]) |=> ($stable(mode_word) && $stable(grp_is_in)));

  // R7: an accepted word is what the readback source holds next cycle
  a_r7_word_stored: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && wdata[MODE_SET_BIT]) |=> (mode_word == $past(wdata)));

  // R2: the mode word is only changed by writes
  a_r2_word_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(mode_word));
endmodule

// File: rtl/ppi_port_group.sv
`timescale 1ns/1ps
module ppi_port_group #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         is_in,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] oe
);
  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '0;
    else if (wr_en) latch_q <= wdata;
  end

  // direction flag is already a flop; replicate it across the group
  assign oe = {W{~is_in}};

  // R5: the latch loads regardless of direction
  a_r5_latch_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (latch_q == $past(wdata)));

  // R9: without a data write the latch is untouched
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(latch_q));
endmodule

// File: rtl/ppi_read_mux.sv
`timescale 1ns/1ps
module ppi_read_mux
  import ppi_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 3 * DW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [PW-1:0] pin_in,
  input  logic [DW-1:0] mode_word,
  output logic [DW-1:0] host_rdata
);
  logic [DW-1:0] sel_data;

  always_comb begin
    case (reg_sel_e'(host_addr))
      SEL_PORT_A: sel_data = pin_in[DW-1:0];
      SEL_PORT_B: sel_data = pin_in[2*DW-1:DW];
      SEL_PORT_C: sel_data = pin_in[3*DW-1:2*DW];
      default:    sel_data = mode_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= sel_data;
  end

  // R6: read data holds between read strobes
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: rtl/ppi_channel.sv
`timescale 1ns/1ps
module ppi_channel
  import ppi_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 3 * DW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe
);
  logic [NUM_GROUPS-1:0] grp_wr;
  logic                  mode_wr;
  logic [DW-1:0]         mode_word;
  logic [NUM_GROUPS-1:0] grp_is_in;

  ppi_host_decode u_dec (
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .grp_wr    (grp_wr),
    .mode_wr   (mode_wr)
  );

  ppi_mode_reg #(.DW(DW)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .wdata     (host_wdata),
    .mode_word (mode_word),
    .grp_is_in (grp_is_in)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int W   = grp_width(g, DW);
    localparam int PLO = grp_pin_lo(g, DW);
    localparam int DLO = grp_data_lo(g, DW);

    ppi_port_group #(.W(W)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (grp_wr[g]),
      .wdata   (host_wdata[DLO +: W]),
      .is_in   (grp_is_in[g]),
      .latch_q (pin_out[PLO +: W]),
      .oe      (pin_oe[PLO +: W])
    );
  end

  ppi_read_mux #(.DW(DW)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .pin_in     (pin_in),
    .mode_word  (mode_word),
    .host_rdata (host_rdata)
  );

  // R9: port data writes leave the enables alone
  a_r9_oe_stable_on_data: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr != 2'd3) |=> $stable(pin_oe));

  // R9: mode writes leave the latches alone
  a_r9_out_stable_on_mode: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd3) |=> $stable(pin_out));
endmodule

// File: tb/ppi_channel_test.sv
`timescale 1ns/1ps
module ppi_channel_test;
  localparam int DW = 8;
  localparam int PW = 3 * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    addr = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [PW-1:0] ext = '0;
  logic [PW-1:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  m_cfg   = 8'h9B;
  logic [23:0] m_latch = '0;

  always #2.5 clk = ~clk;

  // resolved line: driven value where enabled, external value elsewhere
  assign pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);

  ppi_channel #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .host_addr(addr), .host_wr(wr), .host_rd(rd),
    .host_wdata(wdata), .host_rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [23:0] oe_of(input logic [7:0] c);
    return {{4{~c[3]}}, {4{~c[0]}}, {8{~c[1]}}, {8{~c[4]}}};
  endfunction

  function automatic logic [7:0] read_exp(input logic [1:0] a);
    logic [23:0] oe, p;
    oe = oe_of(m_cfg);
    p  = (m_latch & oe) | (ext & ~oe);
    case (a)
      2'd0:    return p[7:0];
      2'd1:    return p[15:8];
      2'd2:    return p[23:16];
      default: return m_cfg;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      2'd0: m_latch[7:0]   = d;
      2'd1: m_latch[15:8]  = d;
      2'd2: m_latch[23:16] = d;
      default: if (d[7]) m_cfg = d;
    endcase
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic check_pins(input string req);
    check({req, " oe"}, 32'(pin_oe), 32'(oe_of(m_cfg)));
    check({req, " out"}, 32'(pin_out), 32'(m_latch));
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(1000000.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'd1729);

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check("R2 oe after reset", 32'(pin_oe), 32'h0);
    check("R2 latch after reset", 32'(pin_out), 32'h0);
    check("R2 rdata after reset", 32'(rdata), 32'h0);
    do_read(2'd3, v); check("R2 mode word after reset", 32'(v), 32'h9B);

    // R1 offsets and pin mapping, all inputs
    ext = 24'h123456;
    do_read(2'd0, v); check("R1 port A reads pins 7:0", 32'(v), 32'h56);
    do_read(2'd1, v); check("R1 port B reads pins 15:8", 32'(v), 32'h34);
    do_read(2'd2, v); check("R1 port C reads pins 23:16", 32'(v), 32'h12);

    // R5 latch loads while input, not driven
    do_write(2'd0, 8'hAD);
    check("R5 latch loaded while input", 32'(pin_out), 32'h0000AD);
    check("R5 no drive while input", 32'(pin_oe), 32'h0);
    do_read(2'd0, v); check("R5 input read sees pins not latch", 32'(v), 32'h56);

    // R10 all outputs, R6 readback of driven value
    do_write(2'd3, 8'h80);
    check("R10 0x80 all outputs", 32'(pin_oe), 32'hFFFFFF);
    check("R9 mode write keeps latch", 32'(pin_out), 32'h0000AD);
    do_read(2'd0, v); check("R6 readback of driven port A", 32'(v), 32'hAD);
    do_write(2'd1, 8'h3C);
    do_write(2'd2, 8'hE1);
    check("R1 latch map on pins", 32'(pin_out), 32'hE13CAD);
    check("R9 data writes keep oe", 32'(pin_oe), 32'hFFFFFF);
    do_read(2'd2, v); check("R8 port C readback", 32'(v), 32'hE1);

    // R6 read data held after external change
    ext = 24'hFFFFFF;
    repeat (2) @(negedge clk);
    check("R6 rdata held without strobe", 32'(rdata), 32'hE1);
    ext = 24'h123456;

    // R4 word without bit 7
    do_write(2'd3, 8'h00);
    check("R4 plain word keeps oe", 32'(pin_oe), 32'hFFFFFF);
    do_read(2'd3, v); check("R4 plain word keeps readback", 32'(v), 32'h80);

    // R3 mixed: A in, B in, C both out
    do_write(2'd3, 8'h92);
    check("R3 0x92 enables", 32'(pin_oe), 32'hFF0000);
    do_read(2'd0, v); check("R3 input A reads pins", 32'(v), 32'h56);
    do_read(2'd2, v); check("R8 driven C", 32'(v), 32'hE1);
    do_read(2'd3, v); check("R7 mode readback 0x92", 32'(v), 32'h92);

    // R3 A and B out, C in
    do_write(2'd3, 8'h89);
    check("R3 0x89 enables", 32'(pin_oe), 32'h00FFFF);
    do_read(2'd2, v); check("R8 C both halves input", 32'(v), 32'h12);

    // R8 halves independent: lower in, upper out
    do_write(2'd3, 8'h81);
    check("R8 0x81 enables", 32'(pin_oe), 32'hF0FFFF);
    do_read(2'd2, v); check("R8 mixed C read", 32'(v), 32'hE2);

    // R10 all inputs
    do_write(2'd3, 8'h9B);
    check("R10 0x9B all inputs", 32'(pin_oe), 32'h0);

    // random mix against model
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: do_write(2'($urandom % 3), 8'($urandom));
        1: do_write(2'd3, 8'($urandom));
        2: begin ext = 24'($urandom); @(negedge clk); end
        default: begin
          logic [1:0] a;
          logic [7:0] e;
          a = 2'($urandom % 4);
          e = read_exp(a);
          do_read(a, v);
          check("R6 R7 random read", 32'(v), 32'(e));
        end
      endcase
      check_pins("R3 R5 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule